// File: doc/BRIEF.md
# Apparent Energy Gain and Accumulator

This block turns a pair of unsigned rms magnitudes, one for voltage and one for current, into apparent power by multiplying them. The phase angle between the two waves plays no part. A signed calibration word scales the product by a factor of one plus the word divided by 4096. No offset is subtracted after the multiplication, because any offset correction belongs to the rms values upstream. The scaled power is integrated in a wide accumulator that advances once every fixed number of clock cycles. The accumulator wraps at its width and raises a one-cycle flag when it wraps.

Software reads the upper portion of the accumulator as the apparent energy. A read strobe takes a snapshot of those bits on the clock edge where the strobe is high. The snapshot then stays unchanged until the next strobe. A waveform tap sends the scaled power out on a valid/ready stream at one of four decimated rates. While the tap is stalled, the held sample stays put and any newer samples are discarded. Transfers resume with the next sample produced after the held one has been accepted.

Top module: `aeg_energy_core`

## Requirements
- R1: The scaled power equals floor(vrms × irms × (4096 + G) / 4096), where G is the gain word `gain[11:0]` read as twos complement.
- R2: A gain of 0x000 gives unity, 0x7FF gives a factor of 6143/4096 (about +50%), and 0x800 gives exactly 2048/4096 (about −50%).
- R3: A change on vrms, irms or gain reaches the scaled power two clock edges later: one register for the product and one for the gain stage.
- R4: The accumulator adds the scaled power only on every PRESCALE-th clock edge (default 5), counted from the release of reset. After edge 5k it holds k × S modulo 2^ACC_W.
- R5: The accumulator wraps modulo 2^ACC_W. `rollover` is high for exactly one cycle after an add that carries out of bit ACC_W−1.
- R6: A high `rd_stb` at a clock edge loads `rd_data` with the accumulator's upper READ_W bits as they stood before that edge. Without a strobe, `rd_data` holds its value.
- R7: `wav_rate` values 0, 1, 2 and 3 produce one waveform sample every WAV_DIV × 1, × 2, × 4 and × 8 clock cycles respectively. The first sample appears after edge WAV_DIV × 2^rate following reset.
- R8: While `wav_valid` is high and `wav_ready` is low, `wav_valid` stays high and `wav_data` stays stable. Samples produced during the stall are dropped. After a transfer, `wav_valid` falls unless a new sample is produced on that same edge.
- R9: A synchronous reset clears the accumulator, the add prescaler, the waveform divider and decimation counter, `rd_data`, `rollover` and `wav_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| vrms | input | RMS_W | Unsigned voltage rms magnitude |
| irms | input | RMS_W | Unsigned current rms magnitude |
| gain | input | 12 | Twos complement gain calibration word |
| rd_stb | input | 1 | Energy read strobe |
| rd_data | output | READ_W | Snapshot of the accumulator's upper bits |
| rollover | output | 1 | One-cycle pulse when the accumulator wraps |
| wav_rate | input | 2 | Waveform decimation select (0 = full rate … 3 = one eighth) |
| wav_valid | output | 1 | Waveform sample available |
| wav_ready | input | 1 | Waveform consumer accepts the sample |
| wav_data | output | 2×RMS_W+1 | Scaled apparent power sample |

## Verification
The bench sweeps rms pairs that include zero and full scale against the extreme gain words, including both ends of the range. A design that treated the gain word as unsigned, or rounded instead of truncating, would show up as wrong energy and wrong waveform values. Long runs at full scale force the accumulator to wrap. An adder that saturated, or that flagged the wrap on the wrong cycle, would give the wrong energy or the wrong number of rollover pulses. A stalled waveform stream checks that the held sample is not overwritten by a newer one. One input change timed exactly at the pipeline boundary catches a stage added to or missing from the gain path.

// File: rtl/aeg_pkg.sv
package aeg_pkg;
  localparam int GAIN_W    = 12;
  localparam int GAIN_FRAC = 12;

  typedef enum logic [1:0] {
    RATE_FULL    = 2'd0,
    RATE_HALF    = 2'd1,
    RATE_QUARTER = 2'd2,
    RATE_EIGHTH  = 2'd3
  } wav_rate_e;

  // number of base ticks minus one between emitted waveform samples
  function automatic logic [2:0] rate_limit(wav_rate_e r);
    case (r)
      RATE_FULL:    return 3'd0;
      RATE_HALF:    return 3'd1;
      RATE_QUARTER: return 3'd3;
      default:      return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/aeg_power_scale.sv
module aeg_power_scale
  import aeg_pkg::*;
#(
  parameter int RMS_W = 16,
  localparam int P_W = 2 * RMS_W,
  localparam int S_W = P_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RMS_W-1:0]  vrms,
  input  logic [RMS_W-1:0]  irms,
  input  logic [GAIN_W-1:0] gain,
  output logic [S_W-1:0]    scaled
);
  localparam int F_W = GAIN_W + 2;
  localparam int M_W = GAIN_FRAC + S_W + 1;
  localparam logic signed [F_W-1:0] UNITY = F_W'(1 << GAIN_FRAC);

  logic [P_W-1:0]          prod_q;
  logic [GAIN_W-1:0]       gain_q;
  logic signed [F_W-1:0]   factor;
  logic signed [M_W-1:0]   mult;

  always_comb begin
    factor = UNITY + $signed({{(F_W-GAIN_W){gain_q[GAIN_W-1]}}, gain_q});
    mult   = $signed({1'b0, prod_q}) * factor;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      gain_q <= '0;
      scaled <= '0;
    end else begin
      prod_q <= vrms * irms;
      gain_q <= gain;
      // apparent power cannot go below zero; clamp a negative product
      scaled <= mult[M_W-1] ? '0 : mult[GAIN_FRAC +: S_W];
    end
  end
endmodule

// File: rtl/aeg_accum.sv
module aeg_accum #(
  parameter int S_W      = 33,
  parameter int ACC_W    = 48,
  parameter int READ_W   = 24,
  parameter int PRESCALE = 5,
  localparam int CNT_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [S_W-1:0]    scaled,
  input  logic              rd_stb,
  output logic [READ_W-1:0] rd_data,
  output logic              rollover
);
  logic [CNT_W-1:0] pre_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             tick;

  always_comb begin
    tick = (pre_q == CNT_W'(PRESCALE - 1));
    sum  = {1'b0, acc_q} + (ACC_W+1)'(scaled);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '0;
      acc_q    <= '0;
      rd_data  <= '0;
      rollover <= 1'b0;
    end else begin
      pre_q    <= tick ? '0 : pre_q + 1'b1;
      rollover <= tick & sum[ACC_W];
      if (tick) acc_q <= sum[ACC_W-1:0];
      if (rd_stb) rd_data <= acc_q[ACC_W-1 -: READ_W];
    end
  end
endmodule

// File: rtl/aeg_wave_tap.sv
module aeg_wave_tap
  import aeg_pkg::*;
#(
  parameter int S_W      = 33,
  parameter int BASE_DIV = 160,
  localparam int BC_W    = $clog2(BASE_DIV)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [S_W-1:0] scaled,
  input  wav_rate_e      rate,
  output logic           valid,
  input  logic           ready,
  output logic [S_W-1:0] data
);
  logic [BC_W-1:0] base_q;
  logic [2:0]      dec_q;
  logic            base_tick;
  logic            emit;

  always_comb begin
    base_tick = (base_q == BC_W'(BASE_DIV - 1));
    emit      = base_tick && (dec_q >= rate_limit(rate));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      dec_q  <= '0;
      valid  <= 1'b0;
      data   <= '0;
    end else begin
      base_q <= base_tick ? '0 : base_q + 1'b1;
      if (base_tick) dec_q <= emit ? '0 : dec_q + 1'b1;
      if (emit && (!valid || ready)) begin
        valid <= 1'b1;
        data  <= scaled;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aeg_energy_core.sv
module aeg_energy_core
  import aeg_pkg::*;
#(
  parameter int RMS_W    = 16,
  parameter int ACC_W    = 48,
  parameter int READ_W   = 24,
  parameter int PRESCALE = 5,
  parameter int WAV_DIV  = 160,
  localparam int S_W     = 2 * RMS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RMS_W-1:0]  vrms,
  input  logic [RMS_W-1:0]  irms,
  input  logic [11:0]       gain,
  input  logic              rd_stb,
  output logic [READ_W-1:0] rd_data,
  output logic              rollover,
  input  logic [1:0]        wav_rate,
  output logic              wav_valid,
  input  logic              wav_ready,
  output logic [S_W-1:0]    wav_data
);
  logic [S_W-1:0] scaled_pw;

  aeg_power_scale #(.RMS_W(RMS_W)) u_scale (
    .clk(clk), .rst(rst), .vrms(vrms), .irms(irms), .gain(gain), .scaled(scaled_pw)
  );

  aeg_accum #(
    .S_W(S_W), .ACC_W(ACC_W), .READ_W(READ_W), .PRESCALE(PRESCALE)
  ) u_acc (
    .clk(clk), .rst(rst), .scaled(scaled_pw), .rd_stb(rd_stb),
    .rd_data(rd_data), .rollover(rollover)
  );

  aeg_wave_tap #(.S_W(S_W), .BASE_DIV(WAV_DIV)) u_wave (
    .clk(clk), .rst(rst), .scaled(scaled_pw), .rate(wav_rate_e'(wav_rate)),
    .valid(wav_valid), .ready(wav_ready), .data(wav_data)
  );
endmodule

// File: rtl/aeg_energy_chk.sv
module aeg_energy_chk #(
  parameter int READ_W   = 24,
  parameter int S_W      = 33,
  parameter int PRESCALE = 5,
  localparam int CNT_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_stb,
  input logic [READ_W-1:0] rd_data,
  input logic              rollover,
  input logic              wav_valid,
  input logic              wav_ready,
  input logic [S_W-1:0]    wav_data
);
  logic [CNT_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= (phase_q == CNT_W'(PRESCALE - 1)) ? '0 : phase_q + 1'b1;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wav_valid && !wav_ready) |=> (wav_valid && $stable(wav_data)));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> $stable(rd_data));

  // R5
  roll_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rollover |=> !rollover);

  // R4
  roll_cadence_chk: assert property (@(posedge clk) disable iff (rst)
    rollover |-> (phase_q == '0));
endmodule

bind aeg_energy_core aeg_energy_chk #(
  .READ_W(READ_W), .S_W(S_W), .PRESCALE(PRESCALE)
) u_chk (
  .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_data(rd_data), .rollover(rollover),
  .wav_valid(wav_valid), .wav_ready(wav_ready), .wav_data(wav_data)
);

// File: tb/aeg_energy_core_test.sv
module aeg_energy_core_test;
  localparam int RMS_W  = 8;
  localparam int ACC_W  = 24;
  localparam int READ_W = 12;
  localparam int PRE    = 5;
  localparam int WDIV   = 8;
  localparam int S_W    = 2 * RMS_W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RMS_W-1:0] vrms = '0, irms = '0;
  logic [11:0] gain = '0;
  logic rd_stb = 1'b0;
  logic [READ_W-1:0] rd_data;
  logic rollover;
  logic [1:0] wav_rate = 2'd0;
  logic wav_valid;
  logic wav_ready = 1'b1;
  logic [S_W-1:0] wav_data;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  aeg_energy_core #(
    .RMS_W(RMS_W), .ACC_W(ACC_W), .READ_W(READ_W), .PRESCALE(PRE), .WAV_DIV(WDIV)
  ) uut (
    .clk(clk), .rst(rst), .vrms(vrms), .irms(irms), .gain(gain),
    .rd_stb(rd_stb), .rd_data(rd_data), .rollover(rollover),
    .wav_rate(wav_rate), .wav_valid(wav_valid), .wav_ready(wav_ready), .wav_data(wav_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint scaled_ref(longint v, longint i, int g);
    return (v * i * (4096 + g)) >>> 12;
  endfunction

  function automatic int gsign(logic [11:0] w);
    return int'($signed(w));
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start(input int v, input int i, input logic [11:0] g, input logic [1:0] r, input bit rdy);
    rst = 1'b1; vrms = RMS_W'(v); irms = RMS_W'(i); gain = g;
    wav_rate = r; wav_ready = rdy; rd_stb = 1'b0;
    step();
    rst = 1'b0;
  endtask

  task automatic run_case(input int v, input int i, input logic [11:0] g, input int n);
    longint s, k, tot;
    int rolls;
    string tag;
    s = scaled_ref(v, i, gsign(g));
    tag = (g == 12'h7FF || g == 12'h800 || g == 12'h000) ? "R2" : "R1";
    rolls = 0;
    start(v, i, g, 2'd0, 1'b1);
    for (int e = 1; e <= n; e++) begin
      step();
      if (rollover) rolls++;
      if (e == WDIV) check(wav_valid && (wav_data == S_W'(s)), tag, longint'(wav_data), s);
    end
    rd_stb = 1'b1;
    step();
    rd_stb = 1'b0;
    k = n / PRE;
    tot = k * s;
    // R4: energy after floor(n/5) adds
    check(rd_data == READ_W'((tot % (64'd1 << ACC_W)) >> (ACC_W - READ_W)), "R4",
          longint'(rd_data), (tot % (64'd1 << ACC_W)) >> (ACC_W - READ_W));
    // R5: one rollover pulse per wrap
    check(rolls == int'(tot >> ACC_W), "R5", rolls, tot >> ACC_W);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    automatic int vs[5] = '{0, 1, 37, 200, 255};
    automatic int is_[4] = '{0, 3, 128, 255};
    automatic logic [11:0] gs[6] = '{12'h000, 12'h7FF, 12'h800, 12'h001, 12'hFFF, 12'hC18};
    automatic int idx = 0;
    logic [READ_W-1:0] held;
    int cnt;
    longint s1, s2;

    // R9: reset state
    step(); step();
    check(rd_data == '0 && !rollover && !wav_valid, "R9", longint'(rd_data), 0);

    // R1 R2 R4 R5 sweep
    foreach (vs[a]) foreach (is_[b]) foreach (gs[c]) begin
      run_case(vs[a], is_[b], gs[c], 20 + 11 * (idx % 9));
      idx++;
    end
    // long full-scale runs force wraps (R5)
    run_case(255, 255, 12'h7FF, 1800);
    run_case(255, 254, 12'h000, 1300);

    // R6: snapshot holds without a strobe
    held = rd_data;
    for (int e = 0; e < 30; e++) step();
    check(rd_data == held, "R6", longint'(rd_data), longint'(held));
    rd_stb = 1'b1; step(); rd_stb = 1'b0;
    check(rd_data != held, "R6", longint'(rd_data), longint'(held));

    // R9: reset mid-run clears the accumulator
    rst = 1'b1; step(); rst = 1'b0;
    check(!wav_valid && !rollover, "R9", longint'(wav_valid), 0);
    rd_stb = 1'b1; step(); rd_stb = 1'b0;
    check(rd_data == '0, "R9", longint'(rd_data), 0);

    // R3: input change after edge 6 misses the edge-8 capture
    s1 = scaled_ref(100, 100, 0);
    s2 = scaled_ref(50, 100, 0);
    start(100, 100, 12'h000, 2'd0, 1'b1);
    for (int e = 1; e <= WDIV; e++) begin
      step();
      if (e == 6) vrms = 8'd50;
    end
    check(wav_data == S_W'(s1), "R3", longint'(wav_data), s1);
    start(100, 100, 12'h000, 2'd0, 1'b1);
    for (int e = 1; e <= WDIV; e++) begin
      step();
      if (e == 5) vrms = 8'd50;
    end
    check(wav_data == S_W'(s2), "R3", longint'(wav_data), s2);

    // R7: sample rate per mode
    for (int m = 0; m < 4; m++) begin
      start(9, 9, 12'h000, 2'(m), 1'b1);
      cnt = 0;
      for (int e = 1; e <= 256; e++) begin
        step();
        if (wav_valid) cnt++;
      end
      check(cnt == (32 >> m), "R7", cnt, 32 >> m);
    end

    // R8: back-pressure holds oldest sample, drops newer ones
    start(100, 100, 12'h000, 2'd0, 1'b0);
    for (int e = 1; e <= 40; e++) begin
      step();
      if (e == 9) vrms = 8'd50;
    end
    check(wav_valid && wav_data == S_W'(s1), "R8", longint'(wav_data), s1);
    wav_ready = 1'b1;
    step(); // edge 41: transfer
    check(!wav_valid, "R8", longint'(wav_valid), 0);
    for (int e = 42; e <= 48; e++) step();
    check(wav_valid && wav_data == S_W'(s2), "R8", longint'(wav_data), s2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule